// File: doc/BRIEF.md
# Multithreaded Fetch PC Scheduler

This block sits in front of the instruction cache of a multithreaded in-order core. It keeps one program counter for each hardware thread. In every cycle it picks one thread that may issue and presents that thread's PC, with the thread number, as a fetch request. The thread count, PC width, instruction size and reset PC are parameters.

A thread may issue only when the thread controller marks it eligible and it is not waiting on an instruction-cache refill. Threads that can issue share the fetch slot in round-robin order. The search always starts at the thread after the one whose request was last accepted. When the downstream side accepts a request, that thread's PC moves forward by one instruction.

Other agents can change a PC:
- A boot port loads any thread's start address.
- A resolved rollback overwrites a thread's PC with its target.
- A cache miss blocks a thread and rewinds its PC to the address that missed. A later refill-done pulse unblocks it.

Top module: `fetch_pc_sched`

## Requirements
- R1: After reset every thread PC equals RESET_PC and no thread is blocked. The first request offered goes to thread 0.
- R2: `fetch_valid` is high exactly when at least one thread is both eligible (`thread_elig` bit set) and unblocked. `fetch_pc` is then the current PC of thread `fetch_tid`, and that thread is eligible and unblocked.
- R3: The granted thread is the first eligible, unblocked thread found by searching upward from one past the last accepted thread, wrapping from NUM_THREADS-1 to 0.
- R4: In a cycle with no accepted request (`fetch_valid` low or `fetch_ready` low), the search start does not change. The same thread is offered again while it can still issue.
- R5: When `fetch_valid` and `fetch_ready` are both high, the granted thread's PC grows by INSTR_BYTES (4 in the bench) in the next cycle, modulo 2^PC_W. This holds unless a higher-priority write hits that thread.
- R6: A boot write (`boot_we`) loads `boot_pc` into thread `boot_tid` in the next cycle. It has the highest priority of all PC writes.
- R7: A rollback (`rb_valid`) loads `rb_pc` into thread `rb_tid` in the next cycle. It wins over a miss rewind and over the advance of that same thread.
- R8: A miss report (`miss_valid`) blocks thread `miss_tid` from the next cycle on. It also rewinds that thread's PC to `miss_pc`, unless a boot or rollback write hits the same thread. A blocked thread is never granted.
- R9: A refill pulse (`refill_valid`) clears the blocked flag of thread `refill_tid` in the next cycle. If a miss names the same thread in the same cycle, the thread stays blocked.
- R10: A boot, rollback, miss or refill whose thread ID is NUM_THREADS or higher has no effect on any PC or blocked flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_we | input | 1 | Boot PC write strobe |
| boot_tid | input | TID_W | Thread written at boot |
| boot_pc | input | PC_W | Start address to load |
| thread_elig | input | NUM_THREADS | Per-thread eligibility from the thread controller |
| rb_valid | input | 1 | Rollback request |
| rb_tid | input | TID_W | Thread being rolled back |
| rb_pc | input | PC_W | Rollback target |
| miss_valid | input | 1 | Instruction-cache miss report |
| miss_tid | input | TID_W | Thread that missed |
| miss_pc | input | PC_W | Address that missed |
| refill_valid | input | 1 | Refill-done pulse |
| refill_tid | input | TID_W | Thread whose line arrived |
| fetch_ready | input | 1 | Downstream accepts the request |
| fetch_valid | output | 1 | A fetch request is offered |
| fetch_tid | output | TID_W | Thread of the offered request |
| fetch_pc | output | PC_W | PC of the offered request |

## Verification
The bench builds the block with NUM_THREADS=3, PC_W=12, INSTR_BYTES=4 and RESET_PC=0x100. Three threads is not a power of two, so the wrap of the round-robin search runs through the modulo variant. The 2-bit thread ID fields can also carry the unused value 3, which makes the out-of-range cases of R10 reachable. A 12-bit PC is short enough that advances and loads near 0xFFC wrap within the run. A long pseudo-random sweep mixes eligibility, ready, boot, rollback, miss and refill traffic against an arithmetic model, after directed phases for each priority collision.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // Source of the next value of one thread PC, highest priority first.
   typedef enum logic [2:0] {
      SRC_HOLD = 3'd0,
      SRC_BOOT = 3'd1,
      SRC_RB   = 3'd2,
      SRC_MISS = 3'd3,
      SRC_STEP = 3'd4
   } pc_src_e;

endpackage

// File: rtl/pcs_rr_pick.sv
module pcs_rr_pick #(
   parameter int N     = 4,
   parameter int TID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             accept,
   output logic             gnt_valid,
   output logic [TID_W-1:0] gnt_tid
);

   localparam bit POW2 = ((1 << TID_W) == N);

   logic [TID_W-1:0] last_q;

   generate
      if (POW2) begin : g_trunc
         // Power-of-two count: wrap by truncation.
         always_comb begin
            gnt_valid = 1'b0;
            gnt_tid   = '0;
            for (int k = N; k >= 1; k--) begin
               if (req[last_q + TID_W'(k)]) begin
                  gnt_valid = 1'b1;
                  gnt_tid   = last_q + TID_W'(k);
               end
            end
         end
      end else begin : g_mod
         // Any other count: wrap by modulo.
         always_comb begin
            int idx;
            gnt_valid = 1'b0;
            gnt_tid   = '0;
            for (int k = N; k >= 1; k--) begin
               idx = (int'(last_q) + k) % N;
               if (req[idx]) begin
                  gnt_valid = 1'b1;
                  gnt_tid   = TID_W'(idx);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      last_q <= TID_W'(N - 1);
      else if (accept) last_q <= gnt_tid;
   end

   // R4
   hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(last_q));

   // R3
   rr_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (&req) -> (gnt_tid == (($past(gnt_tid) == TID_W'(N - 1)) ? '0 : $past(gnt_tid) + 1'b1)));

endmodule

// File: rtl/pcs_block_track.sv
module pcs_block_track #(
   parameter int N     = 4,
   parameter int TID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             miss_valid,
   input  logic [TID_W-1:0] miss_tid,
   input  logic             refill_valid,
   input  logic [TID_W-1:0] refill_tid,
   output logic [N-1:0]     blocked
);

   generate
      for (genvar t = 0; t < N; t++) begin : g_thr
         logic set_t, clr_t;
         assign set_t = miss_valid   && (miss_tid   == TID_W'(t));
         assign clr_t = refill_valid && (refill_tid == TID_W'(t));

         always_ff @(posedge clk) begin
            if (!rst_n)     blocked[t] <= 1'b0;
            else if (set_t) blocked[t] <= 1'b1;
            else if (clr_t) blocked[t] <= 1'b0;
         end

         // R8
         miss_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (miss_valid && miss_tid == TID_W'(t)) |=> blocked[t]);

         // R9
         refill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (refill_valid && refill_tid == TID_W'(t) && !(miss_valid && miss_tid == TID_W'(t)))
            |=> !blocked[t]);
      end
   endgenerate

endmodule

// File: rtl/pcs_pc_bank.sv
module pcs_pc_bank
   import pcs_pkg::*;
#(
   parameter int          N           = 4,
   parameter int          TID_W       = 2,
   parameter int          PC_W        = 32,
   parameter int          INSTR_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     boot_we,
   input  logic [TID_W-1:0]         boot_tid,
   input  logic [PC_W-1:0]          boot_pc,
   input  logic                     rb_valid,
   input  logic [TID_W-1:0]         rb_tid,
   input  logic [PC_W-1:0]          rb_pc,
   input  logic                     miss_valid,
   input  logic [TID_W-1:0]         miss_tid,
   input  logic [PC_W-1:0]          miss_pc,
   input  logic                     step_valid,
   input  logic [TID_W-1:0]         step_tid,
   output logic [N-1:0][PC_W-1:0]   pcs
);

   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   generate
      for (genvar t = 0; t < N; t++) begin : g_thr
         pc_src_e src;
         logic hit_boot, hit_rb, hit_miss, hit_step;

         assign hit_boot = boot_we    && (boot_tid == TID_W'(t));
         assign hit_rb   = rb_valid   && (rb_tid   == TID_W'(t));
         assign hit_miss = miss_valid && (miss_tid == TID_W'(t));
         assign hit_step = step_valid && (step_tid == TID_W'(t));

         always_comb begin
            if (hit_boot)      src = SRC_BOOT;
            else if (hit_rb)   src = SRC_RB;
            else if (hit_miss) src = SRC_MISS;
            else if (hit_step) src = SRC_STEP;
            else               src = SRC_HOLD;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) pcs[t] <= RESET_PC;
            else begin
               case (src)
                  SRC_BOOT: pcs[t] <= boot_pc;
                  SRC_RB:   pcs[t] <= rb_pc;
                  SRC_MISS: pcs[t] <= miss_pc;
                  SRC_STEP: pcs[t] <= pcs[t] + STEP;
                  default:  pcs[t] <= pcs[t];
               endcase
            end
         end

         // R6
         boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (boot_we && boot_tid == TID_W'(t)) |=> pcs[t] == $past(boot_pc));

         // R7
         rb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rb_valid && rb_tid == TID_W'(t) && !(boot_we && boot_tid == TID_W'(t)))
            |=> pcs[t] == $past(rb_pc));

         // R5
         step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (step_valid && step_tid == TID_W'(t) && !(boot_we && boot_tid == TID_W'(t))
             && !(rb_valid && rb_tid == TID_W'(t)) && !(miss_valid && miss_tid == TID_W'(t)))
            |=> pcs[t] == $past(pcs[t]) + STEP);

         // R8
         miss_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (miss_valid && miss_tid == TID_W'(t) && !(boot_we && boot_tid == TID_W'(t))
             && !(rb_valid && rb_tid == TID_W'(t)))
            |=> pcs[t] == $past(miss_pc));
      end
   endgenerate

endmodule

// File: rtl/fetch_pc_sched.sv
module fetch_pc_sched #(
   parameter int              NUM_THREADS = 4,
   parameter int              PC_W        = 32,
   parameter int              INSTR_BYTES = 4,
   parameter logic [PC_W-1:0] RESET_PC    = '0,
   localparam int             TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   boot_we,
   input  logic [TID_W-1:0]       boot_tid,
   input  logic [PC_W-1:0]        boot_pc,
   input  logic [NUM_THREADS-1:0] thread_elig,
   input  logic                   rb_valid,
   input  logic [TID_W-1:0]       rb_tid,
   input  logic [PC_W-1:0]        rb_pc,
   input  logic                   miss_valid,
   input  logic [TID_W-1:0]       miss_tid,
   input  logic [PC_W-1:0]        miss_pc,
   input  logic                   refill_valid,
   input  logic [TID_W-1:0]       refill_tid,
   input  logic                   fetch_ready,
   output logic                   fetch_valid,
   output logic [TID_W-1:0]       fetch_tid,
   output logic [PC_W-1:0]        fetch_pc
);

   // Elaboration-time parameter checks.
   generate
      if (NUM_THREADS < 2) begin : g_bad_threads
         $error("fetch_pc_sched: NUM_THREADS must be at least 2");
      end
      if (PC_W < 8) begin : g_bad_pcw
         $error("fetch_pc_sched: PC_W must be at least 8");
      end
      if (INSTR_BYTES < 1 || (INSTR_BYTES & (INSTR_BYTES - 1)) != 0) begin : g_bad_step
         $error("fetch_pc_sched: INSTR_BYTES must be a power of two");
      end
   endgenerate

   logic [NUM_THREADS-1:0]           blocked;
   logic [NUM_THREADS-1:0]           ready_mask;
   logic [NUM_THREADS-1:0][PC_W-1:0] pcs;
   logic                             accept;

   assign ready_mask = thread_elig & ~blocked;
   assign accept     = fetch_valid && fetch_ready;
   assign fetch_pc   = pcs[fetch_tid];

   pcs_rr_pick #(.N(NUM_THREADS), .TID_W(TID_W)) u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (ready_mask),
      .accept    (accept),
      .gnt_valid (fetch_valid),
      .gnt_tid   (fetch_tid)
   );

   pcs_block_track #(.N(NUM_THREADS), .TID_W(TID_W)) u_block (
      .clk          (clk),
      .rst_n        (rst_n),
      .miss_valid   (miss_valid),
      .miss_tid     (miss_tid),
      .refill_valid (refill_valid),
      .refill_tid   (refill_tid),
      .blocked      (blocked)
   );

   pcs_pc_bank #(
      .N(NUM_THREADS), .TID_W(TID_W), .PC_W(PC_W),
      .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .boot_we    (boot_we),
      .boot_tid   (boot_tid),
      .boot_pc    (boot_pc),
      .rb_valid   (rb_valid),
      .rb_tid     (rb_tid),
      .rb_pc      (rb_pc),
      .miss_valid (miss_valid),
      .miss_tid   (miss_tid),
      .miss_pc    (miss_pc),
      .step_valid (accept),
      .step_tid   (fetch_tid),
      .pcs        (pcs)
   );

   // R2
   grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (thread_elig[fetch_tid] && !blocked[fetch_tid]));

   // R2
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_mask == '0) |-> !fetch_valid);

   // R1
   first_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rst_n) && thread_elig[0] && !blocked[0]) |-> fetch_tid == '0);

endmodule

// File: tb/sim_fetch_pc_sched.sv
`timescale 1ns/1ps
module sim_fetch_pc_sched;

   localparam int NT = 3;
   localparam int PW = 12;
   localparam int TW = 2;
   localparam logic [PW-1:0] RPC = 12'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic boot_we = 0, rb_valid = 0, miss_valid = 0, refill_valid = 0, fetch_ready = 0;
   logic [TW-1:0] boot_tid = 0, rb_tid = 0, miss_tid = 0, refill_tid = 0;
   logic [PW-1:0] boot_pc = 0, rb_pc = 0, miss_pc = 0;
   logic [NT-1:0] thread_elig = 0;
   logic fetch_valid;
   logic [TW-1:0] fetch_tid;
   logic [PW-1:0] fetch_pc;

   int checks = 0;
   int errors = 0;

   logic [PW-1:0] m_pc [NT];
   logic          m_blk [NT];
   int            m_last;
   logic          e_valid;
   int            e_tid;

   always #2.5 clk = ~clk;

   fetch_pc_sched #(.NUM_THREADS(NT), .PC_W(PW), .INSTR_BYTES(4), .RESET_PC(RPC)) u0 (
      .clk(clk), .rst_n(rst_n),
      .boot_we(boot_we), .boot_tid(boot_tid), .boot_pc(boot_pc),
      .thread_elig(thread_elig),
      .rb_valid(rb_valid), .rb_tid(rb_tid), .rb_pc(rb_pc),
      .miss_valid(miss_valid), .miss_tid(miss_tid), .miss_pc(miss_pc),
      .refill_valid(refill_valid), .refill_tid(refill_tid),
      .fetch_ready(fetch_ready),
      .fetch_valid(fetch_valid), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic predict();
      e_valid = 1'b0;
      e_tid   = 0;
      for (int k = 1; k <= NT; k++) begin
         int idx;
         idx = (m_last + k) % NT;
         if (!e_valid && thread_elig[idx] && !m_blk[idx]) begin
            e_valid = 1'b1;
            e_tid   = idx;
         end
      end
   endtask

   task automatic step(input string tag);
      logic acc;
      #1;
      predict();
      chk({tag, " valid"}, int'(fetch_valid), int'(e_valid));
      if (e_valid) begin
         chk({tag, " tid"}, int'(fetch_tid), e_tid);
         chk({tag, " pc"}, int'(fetch_pc), int'(m_pc[e_tid]));
      end
      acc = e_valid && fetch_ready;
      @(posedge clk);
      for (int t = 0; t < NT; t++) begin
         if (boot_we && int'(boot_tid) == t)        m_pc[t] = boot_pc;
         else if (rb_valid && int'(rb_tid) == t)    m_pc[t] = rb_pc;
         else if (miss_valid && int'(miss_tid) == t) m_pc[t] = miss_pc;
         else if (acc && e_tid == t)                m_pc[t] = m_pc[t] + 12'd4;
         if (miss_valid && int'(miss_tid) == t)          m_blk[t] = 1'b1;
         else if (refill_valid && int'(refill_tid) == t) m_blk[t] = 1'b0;
      end
      if (acc) m_last = e_tid;
      @(negedge clk);
   endtask

   task automatic quiet();
      boot_we = 0; rb_valid = 0; miss_valid = 0; refill_valid = 0;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      for (int t = 0; t < NT; t++) begin m_pc[t] = RPC; m_blk[t] = 1'b0; end
      m_last = NT - 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state: nothing offered with no eligibility, then thread 0 first
      step("R1 idle");
      thread_elig = 3'b111; fetch_ready = 0;
      #1;
      chk("R1 first tid", int'(fetch_tid), 0);
      chk("R1 reset pc", int'(fetch_pc), int'(RPC));
      step("R1 model");

      // R6 boot loads, one per thread, also onto a near-wrap address
      for (int t = 0; t < NT; t++) begin
         boot_we = 1; boot_tid = TW'(t); boot_pc = 12'h200 + 12'(t * 16);
         step("R6 boot");
      end
      boot_tid = 2'd2; boot_pc = 12'hFF8; step("R6 boot2");
      // R10 boot to nonexistent thread 3
      boot_tid = 2'd3; boot_pc = 12'h777; step("R10 boot");
      quiet();

      // R3 R5 round robin over all threads, wrapping PC of thread 2
      fetch_ready = 1;
      for (int i = 0; i < 9; i++) step("R3/R5 rr");

      // R4 ready low holds the same thread
      fetch_ready = 0;
      for (int i = 0; i < 3; i++) step("R4 hold");
      thread_elig = 3'b000; step("R2 none");
      thread_elig = 3'b101; fetch_ready = 1;
      for (int i = 0; i < 4; i++) step("R3 skip");

      // R7 rollback beats advance and miss on the granted thread
      thread_elig = 3'b111;
      #1; predict();
      rb_valid = 1; rb_tid = TW'(e_tid); rb_pc = 12'h4A0;
      miss_valid = 1; miss_tid = TW'(e_tid); miss_pc = 12'h555;
      step("R7 rollback");
      quiet();
      refill_valid = 1; refill_tid = TW'(e_tid); step("R9 refill"); quiet();
      // R6 boot beats rollback
      boot_we = 1; boot_tid = 2'd1; boot_pc = 12'h0C0;
      rb_valid = 1; rb_tid = 2'd1; rb_pc = 12'h0D0;
      step("R6 priority"); quiet();

      // R8 miss blocks thread 1 and rewinds it
      miss_valid = 1; miss_tid = 2'd1; miss_pc = 12'h300; step("R8 miss"); quiet();
      for (int i = 0; i < 4; i++) step("R8 blocked");
      // R9 refill with simultaneous miss keeps block
      refill_valid = 1; refill_tid = 2'd1; miss_valid = 1; miss_tid = 2'd1; miss_pc = 12'h310;
      step("R9 collide"); quiet();
      for (int i = 0; i < 3; i++) step("R9 still");
      // R10 out-of-range refill, rollback and miss
      refill_valid = 1; refill_tid = 2'd3; rb_valid = 1; rb_tid = 2'd3; rb_pc = 12'h999;
      miss_valid = 1; miss_tid = 2'd3; miss_pc = 12'h888;
      step("R10 range"); quiet();
      for (int i = 0; i < 4; i++) step("R10 after");
      refill_valid = 1; refill_tid = 2'd1; step("R9 release"); quiet();
      for (int i = 0; i < 4; i++) step("R9 back");

      // Sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 under mixed traffic
      lf = 16'hACE1;
      for (int c = 0; c < 4000; c++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         thread_elig  = lf[2:0];
         fetch_ready  = lf[3] | lf[4];
         boot_we      = (lf[8:5] == 4'd0);
         boot_tid     = lf[10:9];
         boot_pc      = {lf[15:6], 2'b00};
         rb_valid     = (lf[7:5] == 3'd7);
         rb_tid       = lf[12:11];
         rb_pc        = {lf[11:2], 2'b00};
         miss_valid   = (lf[15:13] == 3'd5);
         miss_tid     = lf[1:0];
         miss_pc      = {lf[13:4], 2'b00};
         refill_valid = lf[14] & lf[9];
         refill_tid   = lf[6:5];
         step("R2/R3/R5/R8/R9 sweep");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule